// File: doc/BRIEF.md
# Byte-Wide Bridge to 16-bit Registers with a Shared High-Byte Latch

The bridge places a bank of 16-bit registers on an 8-bit processor data bus. Each register takes up two byte addresses. One 8-bit latch holds a high byte between the two halves of an access, and every register in the bank uses that same latch. A byte access to the low half is the one that takes effect. A low-half write loads the latched high byte and the new low byte into the register together. A low-half read returns the low byte of the register's live input and, on the same clock edge, copies that input's high byte into the latch. The second byte of the word therefore comes from the same instant as the first.

The CPU sees a simple byte port: an address, write data, a write strobe and a read strobe. Read data is registered and is valid in the cycle after the strobe. On the peripheral side the block drives the stored words out in parallel and takes a live 16-bit value for each register. To write, software writes the high byte and then the low byte. To read, it reads the low byte and then the high byte.

Top module: `wide_reg_bridge`

## Requirements
- R1: While reset is low, the latch, every stored word and the read data are all zero.
- R2: A write with address bit 0 = 1 (high half) loads the latch with the write data and leaves every stored word unchanged.
- R3: A write with address bit 0 = 0 (low half) sets the word selected by address bits [AW-1:1] to {latch, write data} on that clock edge. The latch does not change.
- R4: A read of a low half, with write strobe low, puts the low byte of the selected live input on the read data in the next cycle. On the same edge it loads the latch with that input's high byte.
- R5: A read of a high half returns the latch contents, not the live high byte, and leaves the latch unchanged.
- R6: The latch is shared. A high-half write aimed at one register, followed by a low-half write to another register, commits the latched byte into the second register. The first register keeps its old value.
- R7: After reset, a low-half write with no high-half write before it stores zero in the high byte.
- R8: When the write and read strobes are both high, only the write takes place. The read data and the latch are not updated by the read.
- R9: With both strobes low, the latch, the stored words and the read data hold their values, even when the live inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | AW = log2(NREG)+1 | Byte address: bit 0 selects the half (1 = high), upper bits select the register |
| cpu_wdata | input | 8 | Write data byte |
| cpu_we | input | 1 | Write strobe, one cycle per access |
| cpu_re | input | 1 | Read strobe, one cycle per access |
| cpu_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| reg_q | output | 16*NREG | Stored words; register i occupies bits [16i+15:16i] |
| live_d | input | 16*NREG | Live values to be read; register i occupies bits [16i+15:16i] |

## Verification
The assertions check four rules on every cycle. A high-half write never disturbs a stored word. A low-half write commits exactly {latch, data}. A low-half read takes both bytes of the live value on one edge. Idle cycles and write-with-read cycles leave the read path untouched. Only the bench scenarios show the effects that run across several accesses. These are a stale latch byte carried from one register into another, zero high bytes after reset, and a high-half read that still returns the earlier snapshot after the live input has changed.

// File: rtl/bridge_pkg.sv
// Package: shared widths and the decoded access type for the byte bridge.
// Assumes a byte-wide CPU bus and 16-bit peripheral words.
package bridge_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // One decoded CPU access; at most one field is set in any cycle.
    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic rd_lo;
        logic rd_hi;
    } access_t;
endpackage

// File: rtl/access_decode.sv
// Access decoder: splits the byte address into a register index and a half
// select, and turns the strobes into one access kind. Write takes priority
// over read when both strobes are high. Assumes NREG is a power of two >= 2.
module access_decode #(
    parameter int NREG = 4,
    localparam int IW = $clog2(NREG),
    localparam int AW = IW + 1
) (
    input  logic [AW-1:0]      cpu_addr,
    input  logic               cpu_we,
    input  logic               cpu_re,
    output bridge_pkg::access_t acc,
    output logic [IW-1:0]      idx
);
    logic hi_half;

    // Classify the current bus cycle.
    always_comb begin
        hi_half   = cpu_addr[0];
        idx       = cpu_addr[AW-1:1];
        acc.wr_hi = cpu_we & hi_half;
        acc.wr_lo = cpu_we & ~hi_half;
        acc.rd_hi = cpu_re & ~cpu_we & hi_half;
        acc.rd_lo = cpu_re & ~cpu_we & ~hi_half;
    end
endmodule

// File: rtl/shared_temp.sv
// Shared high-byte latch: loaded by high-half writes and by low-half reads
// (snapshot of the live high byte). Assumes acc is one-hot or empty.
module shared_temp (
    input  logic                clk,
    input  logic                rst_n,
    input  bridge_pkg::access_t acc,
    input  bridge_pkg::byte_t   wdata,
    input  bridge_pkg::byte_t   snap_hi,
    output bridge_pkg::byte_t   temp_q
);
    // Update the latch from a write or a read snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            temp_q <= '0;
        else if (acc.wr_hi)
            temp_q <= wdata;
        else if (acc.rd_lo)
            temp_q <= snap_hi;
    end
endmodule

// File: rtl/word_bank.sv
// Word bank: NREG 16-bit registers, each committed in one edge from the
// shared latch and the low write byte. Assumes idx is in range.
module word_bank #(
    parameter int NREG = 4,
    localparam int IW = $clog2(NREG),
    localparam int WW = bridge_pkg::WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bridge_pkg::access_t acc,
    input  logic [IW-1:0]       idx,
    input  bridge_pkg::byte_t   temp_q,
    input  bridge_pkg::byte_t   wdata,
    output logic [NREG*WW-1:0]  reg_q
);
    for (genvar g = 0; g < NREG; g++) begin : g_word
        bridge_pkg::word_t word_q;

        // Commit {latch, low byte} when this word's low half is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (acc.wr_lo && idx == IW'(g))
                word_q <= {temp_q, wdata};
        end

        assign reg_q[g*WW +: WW] = word_q;
    end
endmodule

// File: rtl/read_port.sv
// Read port: selects the addressed live word, offers its high byte for the
// latch snapshot, and registers the byte returned to the CPU.
module read_port #(
    parameter int NREG = 4,
    localparam int IW = $clog2(NREG),
    localparam int WW = bridge_pkg::WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bridge_pkg::access_t acc,
    input  logic [IW-1:0]       idx,
    input  logic [NREG*WW-1:0]  live_d,
    input  bridge_pkg::byte_t   temp_q,
    output bridge_pkg::byte_t   snap_hi,
    output bridge_pkg::byte_t   cpu_rdata
);
    bridge_pkg::word_t live_w [NREG];
    bridge_pkg::word_t sel_w;

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign live_w[g] = live_d[g*WW +: WW];
    end

    // Pick the addressed live word.
    always_comb begin
        sel_w   = live_w[idx];
        snap_hi = sel_w[WW-1:bridge_pkg::BYTE_W];
    end

    // Register the read byte: live low byte or the latch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_rdata <= '0;
        else if (acc.rd_lo)
            cpu_rdata <= sel_w[bridge_pkg::BYTE_W-1:0];
        else if (acc.rd_hi)
            cpu_rdata <= temp_q;
    end
endmodule

// File: rtl/wide_reg_bridge.sv
// Top: byte-bus bridge to NREG 16-bit registers with one shared high-byte
// latch. Address bit 0 picks the half (1 = high); upper bits pick the word.
// Assumes single-cycle strobes and NREG a power of two >= 2.
module wide_reg_bridge #(
    parameter int NREG = 4,
    localparam int IW = $clog2(NREG),
    localparam int AW = IW + 1,
    localparam int WW = bridge_pkg::WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic               cpu_we,
    input  logic               cpu_re,
    output logic [7:0]         cpu_rdata,
    output logic [NREG*WW-1:0] reg_q,
    input  logic [NREG*WW-1:0] live_d
);
    bridge_pkg::access_t acc;
    logic [IW-1:0]       idx;
    bridge_pkg::byte_t   temp_q;
    bridge_pkg::byte_t   snap_hi;

    access_decode #(.NREG(NREG)) u_dec (
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .acc(acc), .idx(idx)
    );

    shared_temp u_temp (
        .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(cpu_wdata),
        .snap_hi(snap_hi), .temp_q(temp_q)
    );

    word_bank #(.NREG(NREG)) u_bank (
        .clk(clk), .rst_n(rst_n), .acc(acc), .idx(idx),
        .temp_q(temp_q), .wdata(cpu_wdata), .reg_q(reg_q)
    );

    read_port #(.NREG(NREG)) u_rd (
        .clk(clk), .rst_n(rst_n), .acc(acc), .idx(idx), .live_d(live_d),
        .temp_q(temp_q), .snap_hi(snap_hi), .cpu_rdata(cpu_rdata)
    );
endmodule

// File: rtl/wide_reg_bridge_chk.sv
// Checker for wide_reg_bridge: cycle rules on the ports and the shared latch.
module wide_reg_bridge_chk #(
    parameter int NREG = 4,
    localparam int IW = $clog2(NREG),
    localparam int AW = IW + 1,
    localparam int WW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [AW-1:0]      cpu_addr,
    input logic [7:0]         cpu_wdata,
    input logic               cpu_we,
    input logic               cpu_re,
    input logic [7:0]         cpu_rdata,
    input logic [NREG*WW-1:0] reg_q,
    input logic [NREG*WW-1:0] live_d,
    input logic [7:0]         temp_q
);
    logic [WW-1:0] reg_w  [NREG];
    logic [WW-1:0] live_w [NREG];
    logic [WW-1:0] live_sel;
    logic [IW-1:0] idx_q;

    // Unpack the flat buses and pick the addressed live word.
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            reg_w[i]  = reg_q[i*WW +: WW];
            live_w[i] = live_d[i*WW +: WW];
        end
        live_sel = live_w[cpu_addr[AW-1:1]];
    end

    // Remember last cycle's register index.
    always_ff @(posedge clk) idx_q <= cpu_addr[AW-1:1];

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (temp_q == 8'h00 && reg_q == '0 && cpu_rdata == 8'h00));

    a_r2_hi_write_holds_words: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr[0]) |=> ($stable(reg_q) && temp_q == $past(cpu_wdata)));

    a_r3_lo_write_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !cpu_addr[0]) |=>
        (reg_w[idx_q] == {$past(temp_q), $past(cpu_wdata)} && $stable(temp_q)));

    a_r4_lo_read_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_re && !cpu_we && !cpu_addr[0]) |=>
        (cpu_rdata == $past(live_sel[7:0]) && temp_q == $past(live_sel[15:8])));

    a_r5_hi_read_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_re && !cpu_we && cpu_addr[0]) |=>
        (cpu_rdata == $past(temp_q) && $stable(temp_q) && $stable(reg_q)));

    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_re) |=> $stable(cpu_rdata));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_we && !cpu_re) |=>
        ($stable(temp_q) && $stable(reg_q) && $stable(cpu_rdata)));
endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
    .reg_q(reg_q), .live_d(live_d), .temp_q(temp_q)
);

// File: tb/test_wide_reg_bridge.sv
module test_wide_reg_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 4;
    localparam int AW = $clog2(NREG) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic cpu_we = 1'b0;
    logic cpu_re = 1'b0;
    logic [7:0] cpu_rdata;
    logic [NREG*16-1:0] reg_q;
    logic [NREG*16-1:0] live_d = '0;

    int total = 0;
    int bad = 0;
    logic [15:0] m_reg [NREG];
    logic [7:0] m_temp;
    logic [7:0] m_rdata;

    wide_reg_bridge #(.NREG(NREG)) i_wide_reg_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
        .reg_q(reg_q), .live_d(live_d)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREG; i++)
            check(req, reg_q[i*16 +: 16], m_reg[i]);
    endtask

    // One bus cycle; outputs are sampled at the following falling edge.
    task automatic bus(input int r, input bit hi, input logic [7:0] d, input bit w, input bit rd);
        @(negedge clk);
        cpu_addr = AW'(r * 2 + (hi ? 1 : 0));
        cpu_wdata = d;
        cpu_we = w;
        cpu_re = rd;
        @(negedge clk);
        cpu_we = 1'b0;
        cpu_re = 1'b0;
        if (w) begin
            if (hi) m_temp = d;
            else m_reg[r] = {m_temp, d};
        end else if (rd) begin
            if (hi) m_rdata = m_temp;
            else begin
                m_rdata = live_d[r*16 +: 8];
                m_temp = live_d[r*16+8 +: 8];
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) m_reg[i] = '0;
        m_temp = '0;
        m_rdata = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {8'h00, cpu_rdata}, 16'h0000);
        check_bank("R1");
        rst_n = 1'b1;

        // R7: low-only writes after reset carry a zero high byte
        for (int r = 0; r < NREG; r++) begin
            bus(r, 1'b0, 8'h10 + 8'(r), 1'b1, 1'b0);
            check("R7", reg_q[r*16 +: 16], {8'h00, 8'h10 + 8'(r)});
        end

        // R2 / R3: sweep of high-then-low writes over every register
        for (int r = 0; r < NREG; r++) begin
            for (int p = 0; p < 6; p++) begin
                logic [7:0] hb;
                logic [7:0] lb;
                hb = 8'h3C ^ 8'(r * 37 + p * 71);
                lb = 8'hC3 + 8'(r * 13 + p * 29);
                bus(r, 1'b1, hb, 1'b1, 1'b0);
                check_bank("R2");
                bus(r, 1'b0, lb, 1'b1, 1'b0);
                check("R3", reg_q[r*16 +: 16], {hb, lb});
                check_bank("R3");
            end
        end

        // R6: stale latch byte lands in another register
        bus(1, 1'b1, 8'hA5, 1'b1, 1'b0);
        bus(3, 1'b0, 8'h5A, 1'b1, 1'b0);
        check("R6", reg_q[3*16 +: 16], 16'hA55A);
        check_bank("R6");
        bus(0, 1'b0, 8'h11, 1'b1, 1'b0);
        check("R6", reg_q[0 +: 16], 16'hA511);

        // R4 / R5: low read snapshots, high read returns the snapshot
        for (int r = 0; r < NREG; r++) begin
            live_d[r*16 +: 16] = 16'hC0D0 + 16'(r * 16'h0305);
        end
        for (int r = 0; r < NREG; r++) begin
            logic [15:0] lw;
            lw = live_d[r*16 +: 16];
            bus(r, 1'b0, 8'h00, 1'b0, 1'b1);
            check("R4", {8'h00, cpu_rdata}, {8'h00, lw[7:0]});
            live_d[r*16+8 +: 8] = ~lw[15:8];
            bus(r, 1'b1, 8'h00, 1'b0, 1'b1);
            check("R5", {8'h00, cpu_rdata}, {8'h00, lw[15:8]});
            check_bank("R5");
        end

        // R8: both strobes high on a low half: write only
        bus(2, 1'b0, 8'h77, 1'b1, 1'b1);
        check("R8", {8'h00, cpu_rdata}, {8'h00, m_rdata});
        check("R8", reg_q[2*16 +: 16], m_reg[2]);
        bus(2, 1'b1, 8'h00, 1'b0, 1'b1);
        check("R8", {8'h00, cpu_rdata}, {8'h00, m_temp});

        // R9: idle cycles with changing live inputs
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            live_d = live_d ^ {NREG{16'h5A5A}};
            check("R9", {8'h00, cpu_rdata}, {8'h00, m_rdata});
            check_bank("R9");
        end
        bus(0, 1'b1, 8'h00, 1'b0, 1'b1);
        check("R9", {8'h00, cpu_rdata}, {8'h00, m_temp});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule